// File: doc/BRIEF.md
# Dual/Quad Lane Serial Data Shifter

This block is the data path of a serial memory slave that can borrow two extra signal pins as data lanes. Four pads form lanes 0 to 3. Lane 0 is the serial input and lane 1 is the serial output. Lane 2 is normally write protect and lane 3 is normally hold. Each pad reaches the block as an input bit, an output bit and an output enable. The opcode and the address always arrive one bit per clock on lane 0. Only the data phase of a command is widened: to two lanes for the dual commands, or to four lanes for the quad commands. The quad commands are accepted only while a configuration input grants the extra lanes.

The block runs on a fast system clock. It detects the edges of the serial clock (`sck`) by comparing each sample with the one before. Data is captured on rising `sck` edges and launched on falling edges, so both serial clock idle levels work.

The core side is byte-wide:
- For a program command, every completed data byte is presented on `wrData` with a one-cycle `wrValid` strobe.
- For a read command, the core keeps the next byte on `rdData`. A one-cycle `rdAdvance` strobe says that the byte has been taken and the following one is wanted.
- `addrValid` strobes once per accepted command. The address appears on `addr`, and the command type appears on `cmdRead` and `cmdQuad`.

Top module: `quad_lane_shifter`

## Requirements
- R1: After reset `ioOe` is 4'h0, and `addrValid`, `wrValid` and `rdAdvance` are 0.
- R2: The 8-bit opcode and then the 24 address bits are taken most significant bit first from `ioIn[0]` on rising `sck` edges while `csN` is low. After the last address bit, `addrValid` is high for exactly one cycle with the address on `addr`. `cmdRead` is 1 for opcodes 3Bh and 6Bh, and `cmdQuad` is 1 for opcodes 6Bh and 32h.
- R3: For opcode 3Bh (dual read), after the address and 8 dummy clocks each falling `sck` edge drives two bits on `ioOut[1:0]`. Bit 7 goes on lane 1 and bit 6 on lane 0, then bits 5:4, 3:2 and 1:0. `ioOe` is 4'h3 from the first such edge.
- R4: For opcode 6Bh (quad read), after the address and 8 dummy clocks each falling edge drives a nibble on `ioOut[3:0]`: the high nibble first, with bit 7 on lane 3. `ioOe` is 4'hF.
- R5: Each read data byte is taken from `rdData` at the falling edge that begins it, and `rdAdvance` pulses for one cycle just after. Bytes continue for as long as `sck` runs.
- R6: For opcode A2h (dual program), data is sampled from `ioIn[1:0]` on rising edges after the address, in the lane order of R3. Every fourth edge completes a byte, which appears on `wrData` with a one-cycle `wrValid`.
- R7: For opcode 32h (quad program), data is sampled as nibbles from `ioIn[3:0]`, high nibble first. Every second rising edge completes a byte.
- R8: While `qeEn` is 0, opcodes 6Bh and 32h produce no `addrValid`, no `wrValid`, no `rdAdvance`, and `ioOe` stays 4'h0 until `csN` goes high. The next command selected afterwards works normally.
- R9: Any other opcode is ignored in the same way for the rest of that selection.
- R10: In the cycle after `csN` is seen high, `ioOe` is 4'h0, even in the middle of a byte. A partly received program byte produces no `wrValid`. An address cut short produces no `addrValid`.
- R11: `ioOe` is 4'h0 throughout the opcode, address and dummy phases, and throughout program commands.
- R12: The behaviour of R2 to R7 is the same whether `sck` idles low or high between selections.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than `sck` |
| rstN | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low select |
| qeEn | input | 1 | Grants lanes 2 and 3 to data (enables quad opcodes) |
| ioIn | input | 4 | Pad input values of lanes 3..0 |
| ioOut | output | 4 | Pad output values of lanes 3..0 |
| ioOe | output | 4 | Pad output enables of lanes 3..0 |
| addr | output | 24 | Command address, valid with `addrValid` |
| addrValid | output | 1 | One-cycle strobe when the address is complete |
| cmdRead | output | 1 | Current command is a read |
| cmdQuad | output | 1 | Current command uses four lanes |
| wrData | output | 8 | Received program byte |
| wrValid | output | 1 | One-cycle strobe for `wrData` |
| rdData | input | 8 | Next byte to send, supplied by the core |
| rdAdvance | output | 1 | One-cycle strobe: `rdData` has been consumed |

## Verification
The hardest cases to reach are the endings of a command rather than its steady state. These include a select released while a byte is half shifted out or half received, and an idle-high serial clock whose first falling edge comes before any rising edge. A gated quad opcode must also leave nothing behind for the following command. The stimulus drives whole transactions edge by edge, each a different combination:
- read and program commands run with both idle clock levels;
- beat counts are chosen so that the select rises partway through a byte;
- a quad opcode is sent with the lanes not granted, then a valid command follows at once;
- a selection is cut off partway through its address.

// File: rtl/qls_pkg.sv
package qls_pkg;

  typedef enum logic [2:0] {
    PH_OPCODE = 3'd0,
    PH_ADDR   = 3'd1,
    PH_DUMMY  = 3'd2,
    PH_RDATA  = 3'd3,
    PH_WDATA  = 3'd4,
    PH_IGNORE = 3'd5
  } phase_t;

  typedef enum logic [1:0] {
    W_SINGLE = 2'd0,
    W_DUAL   = 2'd1,
    W_QUAD   = 2'd2
  } width_t;

  typedef struct packed {
    logic   capIn;
    logic   shiftAddr;
    logic   emitByte;
    logic   loadOut;
    logic   shiftOut;
    width_t width;
  } strobe_t;

  localparam logic [7:0] OP_RD_DUAL = 8'h3B;
  localparam logic [7:0] OP_RD_QUAD = 8'h6B;
  localparam logic [7:0] OP_PG_DUAL = 8'hA2;
  localparam logic [7:0] OP_PG_QUAD = 8'h32;

  // index of the last beat of a byte for the given lane count
  function automatic logic [1:0] lastBeat(input logic quad);
    return quad ? 2'd1 : 2'd3;
  endfunction

endpackage

// File: rtl/qls_ctrl.sv
module qls_ctrl
  import qls_pkg::*;
#(
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic       csN,
  input  logic       qeEn,
  input  logic [7:0] nextByte,
  output strobe_t    stb,
  output logic       addrValid,
  output logic       cmdRead,
  output logic       cmdQuad
);

  localparam int MAX_A   = (ADDR_BITS > 8) ? ADDR_BITS : 8;
  localparam int MAX_BITS = (DUMMY_BITS > MAX_A) ? DUMMY_BITS : MAX_A;
  localparam int CNT_W   = $clog2(MAX_BITS);
  localparam logic [CNT_W-1:0] OPC_LAST   = CNT_W'(7);
  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'((DUMMY_BITS > 0) ? DUMMY_BITS - 1 : 0);
  localparam phase_t AFTER_ADDR_RD = (DUMMY_BITS > 0) ? PH_DUMMY : PH_RDATA;

  phase_t           phase;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0]       beatCnt;
  logic             sckQ;
  logic             sckRise;
  logic             sckFall;
  logic             opcodeOk;
  logic             opIsRead;
  logic             opIsQuad;
  logic             dataPhase;

  assign sckRise   = sck & ~sckQ;
  assign sckFall   = ~sck & sckQ;
  assign dataPhase = (phase == PH_RDATA) || (phase == PH_WDATA);

  always_comb begin
    opIsRead = (nextByte == OP_RD_DUAL) || (nextByte == OP_RD_QUAD);
    opIsQuad = (nextByte == OP_RD_QUAD) || (nextByte == OP_PG_QUAD);
    opcodeOk = (nextByte == OP_RD_DUAL) || (nextByte == OP_PG_DUAL) ||
               (opIsQuad && qeEn);
  end

  // strobes to the datapath
  always_comb begin
    stb = '0;
    stb.width = dataPhase ? (cmdQuad ? W_QUAD : W_DUAL) : W_SINGLE;
    if (!csN) begin
      unique case (phase)
        PH_OPCODE: stb.capIn     = sckRise;
        PH_ADDR:   stb.shiftAddr = sckRise;
        PH_RDATA: begin
          stb.loadOut  = sckFall && (beatCnt == 2'd0);
          stb.shiftOut = sckFall && (beatCnt != 2'd0);
        end
        PH_WDATA: begin
          stb.capIn    = sckRise;
          stb.emitByte = sckRise && (beatCnt == lastBeat(cmdQuad));
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ      <= 1'b0;
      phase     <= PH_OPCODE;
      bitCnt    <= '0;
      beatCnt   <= '0;
      addrValid <= 1'b0;
      cmdRead   <= 1'b0;
      cmdQuad   <= 1'b0;
    end else begin
      sckQ      <= sck;
      addrValid <= 1'b0;
      if (csN) begin
        phase   <= PH_OPCODE;
        bitCnt  <= '0;
        beatCnt <= '0;
        cmdRead <= 1'b0;
        cmdQuad <= 1'b0;
      end else begin
        unique case (phase)
          PH_OPCODE: if (sckRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == OPC_LAST) begin
              bitCnt <= '0;
              if (opcodeOk) begin
                phase   <= PH_ADDR;
                cmdRead <= opIsRead;
                cmdQuad <= opIsQuad;
              end else begin
                phase <= PH_IGNORE;
              end
            end
          end
          PH_ADDR: if (sckRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == ADDR_LAST) begin
              bitCnt    <= '0;
              beatCnt   <= '0;
              addrValid <= 1'b1;
              phase     <= cmdRead ? AFTER_ADDR_RD : PH_WDATA;
            end
          end
          PH_DUMMY: if (sckRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == DUMMY_LAST) begin
              bitCnt <= '0;
              phase  <= PH_RDATA;
            end
          end
          PH_RDATA: if (sckFall)
            beatCnt <= (beatCnt == lastBeat(cmdQuad)) ? 2'd0 : beatCnt + 2'd1;
          PH_WDATA: if (sckRise)
            beatCnt <= (beatCnt == lastBeat(cmdQuad)) ? 2'd0 : beatCnt + 2'd1;
          default: ;
        endcase
      end
    end
  end

  assert_addr_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> !addrValid);

  assert_quad_needs_qe_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && cmdQuad && dataPhase) |-> qeEn);

  assert_no_addr_when_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IGNORE) |=> !addrValid);

endmodule

// File: rtl/qls_datapath.sv
module qls_datapath
  import qls_pkg::*;
#(
  parameter int ADDR_BITS = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  strobe_t              stb,
  input  logic [3:0]           ioIn,
  input  logic [7:0]           rdData,
  output logic [7:0]           nextByte,
  output logic [ADDR_BITS-1:0] addr,
  output logic [7:0]           wrData,
  output logic                 wrValid,
  output logic                 rdAdvance,
  output logic [3:0]           ioOut,
  output logic [3:0]           ioOe
);

  logic [7:0] inSr;
  logic [7:0] outSr;
  logic [7:0] outSrc;

  function automatic logic [3:0] topLanes(input logic [7:0] b, input width_t w);
    unique case (w)
      W_QUAD:  return b[7:4];
      W_DUAL:  return {2'b00, b[7:6]};
      default: return {3'b000, b[7]};
    endcase
  endfunction

  function automatic logic [3:0] laneMask(input width_t w);
    unique case (w)
      W_QUAD:  return 4'hF;
      W_DUAL:  return 4'h3;
      default: return 4'h1;
    endcase
  endfunction

  function automatic logic [7:0] advance(input logic [7:0] b, input width_t w);
    unique case (w)
      W_QUAD:  return {b[3:0], 4'h0};
      W_DUAL:  return {b[5:0], 2'b00};
      default: return {b[6:0], 1'b0};
    endcase
  endfunction

  // lower lanes carry less significant bits of each beat
  always_comb begin
    unique case (stb.width)
      W_QUAD:  nextByte = {inSr[3:0], ioIn[3:0]};
      W_DUAL:  nextByte = {inSr[5:0], ioIn[1:0]};
      default: nextByte = {inSr[6:0], ioIn[0]};
    endcase
  end

  assign outSrc = stb.loadOut ? rdData : outSr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSr      <= '0;
      outSr     <= '0;
      addr      <= '0;
      wrData    <= '0;
      wrValid   <= 1'b0;
      rdAdvance <= 1'b0;
      ioOut     <= '0;
      ioOe      <= '0;
    end else begin
      wrValid   <= stb.emitByte;
      rdAdvance <= stb.loadOut;
      if (stb.capIn)     inSr   <= nextByte;
      if (stb.emitByte)  wrData <= nextByte;
      if (stb.shiftAddr) addr   <= {addr[ADDR_BITS-2:0], ioIn[0]};
      if (stb.loadOut || stb.shiftOut) begin
        ioOut <= topLanes(outSrc, stb.width);
        outSr <= advance(outSrc, stb.width);
      end
      if (csN)              ioOe <= '0;
      else if (stb.loadOut) ioOe <= laneMask(stb.width);
    end
  end

  assert_oe_drop_on_cs_R10: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (ioOe == 4'h0));

  assert_oe_shape_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe == 4'h0) || (ioOe == 4'h3) || (ioOe == 4'hF));

  assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdAdvance |=> !rdAdvance);

  assert_no_oe_while_writing_R11: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (ioOe == 4'h0));

endmodule

// File: rtl/quad_lane_shifter.sv
module quad_lane_shifter
  import qls_pkg::*;
#(
  parameter  int ADDR_BYTES  = 3,
  parameter  int DUMMY_BYTES = 1,
  localparam int ADDR_W      = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              qeEn,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic [ADDR_W-1:0] addr,
  output logic              addrValid,
  output logic              cmdRead,
  output logic              cmdQuad,
  output logic [7:0]        wrData,
  output logic              wrValid,
  input  logic [7:0]        rdData,
  output logic              rdAdvance
);

  localparam int DUMMY_W = 8 * DUMMY_BYTES;

  strobe_t    stb;
  logic [7:0] nextByte;

  qls_ctrl #(
    .ADDR_BITS (ADDR_W),
    .DUMMY_BITS(DUMMY_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sck      (sck),
    .csN      (csN),
    .qeEn     (qeEn),
    .nextByte (nextByte),
    .stb      (stb),
    .addrValid(addrValid),
    .cmdRead  (cmdRead),
    .cmdQuad  (cmdQuad)
  );

  qls_datapath #(
    .ADDR_BITS(ADDR_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .stb      (stb),
    .ioIn     (ioIn),
    .rdData   (rdData),
    .nextByte (nextByte),
    .addr     (addr),
    .wrData   (wrData),
    .wrValid  (wrValid),
    .rdAdvance(rdAdvance),
    .ioOut    (ioOut),
    .ioOe     (ioOe)
  );

endmodule

// File: tb/test_quad_lane_shifter.sv
`timescale 1ns/1ps
module test_quad_lane_shifter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sck = 1'b0;
  logic        csN = 1'b1;
  logic        qeEn = 1'b0;
  logic [3:0]  ioIn = 4'h0;
  logic [3:0]  ioOut;
  logic [3:0]  ioOe;
  logic [23:0] addr;
  logic        addrValid;
  logic        cmdRead;
  logic        cmdQuad;
  logic [7:0]  wrData;
  logic        wrValid;
  logic [7:0]  rdData;
  logic        rdAdvance;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [3:0]  expOe = 4'h0;
  logic [3:0]  expOut = 4'h0;
  logic [23:0] addrQ[$];
  logic        rdQ[$];
  logic        quadQ[$];
  logic [7:0]  wrQ[$];
  int advCount = 0;
  int advBase = 0;
  int seed = 0;

  function automatic logic [7:0] pat(input int n);
    return 8'(n * 37 + 90);
  endfunction

  // behavioural core: serves byte k of the stream after k advances
  assign rdData = pat(seed + advCount - advBase);

  always #2 clk = ~clk;

  quad_lane_shifter i_quad_lane_shifter (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .qeEn(qeEn),
    .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe), .addr(addr),
    .addrValid(addrValid), .cmdRead(cmdRead), .cmdQuad(cmdQuad),
    .wrData(wrData), .wrValid(wrValid), .rdData(rdData), .rdAdvance(rdAdvance)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference expectation
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      check(ioOe === expOe, "R3 R4 R10 R11 ioOe", int'(ioOe), int'(expOe));
      if (expOe != 4'h0)
        check((ioOut & expOe) === (expOut & expOe), "R3 R4 R12 ioOut",
              int'(ioOut & expOe), int'(expOut & expOe));
      if (addrValid) begin
        addrQ.push_back(addr);
        rdQ.push_back(cmdRead);
        quadQ.push_back(cmdQuad);
      end
      if (wrValid) wrQ.push_back(wrData);
      if (rdAdvance) advCount++;
    end
  end

  task automatic fallStep(input logic [3:0] din);
    sck = 1'b0;
    ioIn = din;
    repeat (2) @(negedge clk);
  endtask

  task automatic riseStep();
    sck = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      fallStep({3'b000, v[i]});
      riseStep();
    end
  endtask

  task automatic beginTxn(input bit m3);
    addrQ.delete(); rdQ.delete(); quadQ.delete(); wrQ.delete();
    advBase = advCount;
    sck = m3;
    repeat (3) @(negedge clk);
    csN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic endTxn();
    csN = 1'b1;
    expOe = 4'h0;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkAddr(input bit ok, input logic [23:0] a, input bit rd,
                           input bit quad, input string tag);
    if (ok) begin
      check(addrQ.size() == 1, {tag, " R2 addrValid count"}, addrQ.size(), 1);
      if (addrQ.size() == 1) begin
        check(addrQ[0] == a, {tag, " R2 addr"}, int'(addrQ[0]), int'(a));
        check(rdQ[0] == rd, {tag, " R2 cmdRead"}, int'(rdQ[0]), int'(rd));
        check(quadQ[0] == quad, {tag, " R2 cmdQuad"}, int'(quadQ[0]), int'(quad));
      end
    end else begin
      check(addrQ.size() == 0, {tag, " no addrValid"}, addrQ.size(), 0);
    end
  endtask

  task automatic readTxn(input logic [7:0] op, input logic [23:0] a, input bit quad,
                         input int nb, input bit m3, input bit ok, input string tag);
    int bpb;
    int beats;
    int expAdv;
    logic [7:0] b;
    bpb = quad ? 2 : 4;
    seed = int'(a[7:0]);
    beginTxn(m3);
    sendBits({24'h0, op}, 8);
    sendBits({8'h0, a}, 24);
    sendBits(32'h0, 8);
    beats = m3 ? nb : nb + 1;
    for (int i = 0; i < beats; i++) begin
      if (ok) begin
        b = pat(seed + i / bpb);
        expOe = quad ? 4'hF : 4'h3;
        expOut = quad ? ((i % 2 == 0) ? b[7:4] : b[3:0])
                      : {2'b00, b[7 - 2 * (i % 4) -: 2]};
      end
      fallStep(4'h0);
      if (i < nb) riseStep();
    end
    endTxn();
    checkAddr(ok, a, 1'b1, quad, tag);
    expAdv = ok ? (beats + bpb - 1) / bpb : 0;
    check(advCount - advBase == expAdv, {tag, " R5 rdAdvance count"},
          advCount - advBase, expAdv);
  endtask

  task automatic writeTxn(input logic [7:0] op, input logic [23:0] a, input bit quad,
                          input logic [31:0] dw, input int nbytes, input int extra,
                          input bit m3, input bit ok, input string tag);
    logic [7:0] b;
    int bpb;
    int expN;
    bpb = quad ? 2 : 4;
    beginTxn(m3);
    sendBits({24'h0, op}, 8);
    sendBits({8'h0, a}, 24);
    for (int k = 0; k < nbytes; k++) begin
      b = dw[31 - 8 * k -: 8];
      for (int j = 0; j < bpb; j++)
        begin
          fallStep(quad ? ((j == 0) ? b[7:4] : b[3:0]) : {2'b00, b[7 - 2 * j -: 2]});
          riseStep();
        end
    end
    for (int e = 0; e < extra; e++) begin
      fallStep(4'hA);
      riseStep();
    end
    if (!m3) fallStep(4'h0);
    endTxn();
    checkAddr(ok, a, 1'b0, quad, tag);
    expN = ok ? nbytes : 0;
    check(wrQ.size() == expN, {tag, " wrValid count"}, wrQ.size(), expN);
    if (ok && wrQ.size() == expN)
      for (int k = 0; k < nbytes; k++)
        check(wrQ[k] == dw[31 - 8 * k -: 8], {tag, " wrData"},
              int'(wrQ[k]), int'(dw[31 - 8 * k -: 8]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ioOe == 4'h0, "R1 ioOe", int'(ioOe), 0);
    check(!addrValid && !wrValid && !rdAdvance, "R1 strobes",
          int'({addrValid, wrValid, rdAdvance}), 0);

    // R3 dual read, ends mid-byte (R10), lanes not granted (dual needs none)
    readTxn(8'h3B, 24'h123456, 1'b0, 10, 1'b0, 1'b1, "R3 dual read");
    // R4 quad read with lanes granted
    qeEn = 1'b1;
    repeat (2) @(negedge clk);
    readTxn(8'h6B, 24'h3FA5C1, 1'b1, 7, 1'b0, 1'b1, "R4 quad read");
    // R12 quad read with sck idling high
    readTxn(8'h6B, 24'h00FF10, 1'b1, 4, 1'b1, 1'b1, "R12 R4 quad read idle-high");
    // R6 dual program
    writeTxn(8'hA2, 24'h0A0B0C, 1'b0, 32'hC35A_9E00, 3, 0, 1'b0, 1'b1, "R6 dual program");
    // R7 quad program with a trailing half byte (R10)
    writeTxn(8'h32, 24'h200001, 1'b1, 32'h81F0_3CD7, 4, 1, 1'b0, 1'b1, "R7 R10 quad program");
    // R12 dual program, idle high, with partial byte
    writeTxn(8'hA2, 24'h155555, 1'b0, 32'h6E00_0000, 1, 3, 1'b1, 1'b1, "R12 R6 dual program idle-high");

    // R8 quad opcodes refused while lanes not granted
    qeEn = 1'b0;
    repeat (2) @(negedge clk);
    readTxn(8'h6B, 24'h111111, 1'b1, 6, 1'b0, 1'b0, "R8 quad read gated");
    writeTxn(8'h32, 24'h222222, 1'b1, 32'hFFFF_0000, 2, 0, 1'b0, 1'b0, "R8 quad program gated");
    // R8 recovery on the next selection
    readTxn(8'h3B, 24'h2468AC, 1'b0, 8, 1'b1, 1'b1, "R8 dual read after gated");

    // R9 unsupported opcodes
    readTxn(8'h03, 24'h0F0F0F, 1'b0, 8, 1'b0, 1'b0, "R9 single read opcode");
    writeTxn(8'h02, 24'h0F0F0F, 1'b0, 32'h1234_5678, 2, 0, 1'b0, 1'b0, "R9 single program opcode");

    // R10 select released partway through the address
    beginTxn(1'b0);
    sendBits({24'h0, 8'hA2}, 8);
    sendBits(32'h2AB, 10);
    fallStep(4'h0);
    endTxn();
    check(addrQ.size() == 0, "R10 aborted address addrValid", addrQ.size(), 0);
    check(wrQ.size() == 0, "R10 aborted address wrValid", wrQ.size(), 0);

    // R2 follow-up command works after abort
    qeEn = 1'b1;
    repeat (2) @(negedge clk);
    writeTxn(8'h32, 24'h3FFFFF, 1'b1, 32'h0011_2233, 4, 0, 1'b0, 1'b1, "R2 R7 program after abort");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule